// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block maps device-side 32-bit request addresses to 64-bit physical addresses. It uses a small bank of programmable windows instead of page tables. Each window has an inclusive lower bound, an inclusive upper bound (the last byte it covers) and a 64-bit physical base. The lower bound is aligned to the window size, and the size is a power of two from 4 KiB to 1 GiB. A translated address is the physical base plus the request bits that lie below the window size. All enabled windows are compared in parallel. When two or more match, the window with the smallest index wins.

Software programs the windows over a simple 32-bit register port with a 12-bit byte offset. The intended sequence is:

1. Drop the global enable.
2. Write the window fields.
3. Write the window-enable bitmap.
4. Raise the global enable again.

A request that no enabled window covers while translation is on is a fault. The first faulting address is latched and an error flag is raised. That flag drives the interrupt output unless it is masked. Writing the clear register releases the flag.

Requests and responses use valid/ready handshakes. A response appears one clock after its request is accepted.

Top module: `addr_xlate_unit`

## Requirements
- R1: After reset, all of the following read zero: the global enable (offset 0x000, bit 0), the window-enable bitmap (0x020), the raw error flag (0x440), the latched fault address (0x454) and the status word (0x460). In the same state, `irq` and `resp_valid` are low.
- R2: Window n has its fields at byte offset 0x20*n plus a slot offset:
  - 0x30: lower bound.
  - 0x38: upper bound.
  - 0x40: physical base bits 31:0.
  - 0x44: physical base bits 63:32.
  - 0x48: a 32-bit configuration word.
  Each field reads back the last value written to it, and writes are accepted whether or not the global enable is set.
- R3: With the global enable set, a request hits when some window whose bitmap bit n (of 0x020) is 1 satisfies lower ≤ address ≤ upper. A window whose bitmap bit is 0 never matches.
- R4: On a hit, `resp_addr` equals the window base plus (address AND (upper − lower)).
- R5: When several enabled windows cover the same address, the window with the smallest index supplies the translation.
- R6: With the global enable clear, every response has `resp_hit` = 0 and `resp_addr` = the request address zero-extended, and no fault is recorded.
- R7: A miss with the global enable set gives `resp_hit` = 0 and `resp_addr` = 0. It also sets the raw error flag (0x440, bit 0). The fault address register keeps the first faulting address until the flag is cleared.
- R8: `irq` and the masked status (0x444, bit 0) both equal the raw flag AND NOT the mask bit (0x448, bit 0), where mask = 1 suppresses the interrupt.
- R9: Writing 1 to bit 0 of 0x45C clears the raw flag. If a miss is accepted in the same cycle, the flag stays set and the new miss address is latched.
- R10: `req_ready` is high when `resp_valid` is low or `resp_ready` is high. The response arrives exactly one cycle after acceptance. While `resp_ready` is low, `resp_valid`, `resp_hit` and `resp_addr` hold steady.
- R11: Bitmap bits at or above NUM_WIN read zero, and window offsets for indices at or above NUM_WIN read zero.
- R12: Status (0x460) has the global enable in bit 0 and the raw error flag in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | 32 | Device-side request address |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response ready |
| resp_hit | output | 1 | Response came from a window hit |
| resp_addr | output | 64 | Translated physical address |
| irq | output | 1 | Fault interrupt, after the mask |

## Verification
A corrupted bound or base register shows up on the very next response to an address at the edge of that window: the hit flag or the translated value changes one cycle after acceptance. Sweeping one address below, on and above each bound exposes off-by-one compares and a wrong priority order immediately. A fault flag that is stuck or lost shows up on `irq` and in the status register within one cycle of the miss or of the clear write. A fault address that is overwritten when it should be held appears at the next read of the fault-address register after a second miss.

// File: rtl/axu_pkg.sv
package axu_pkg;
  localparam int VA_W = 32;
  localparam int PA_W = 64;
  localparam int RA_W = 12;

  localparam logic [RA_W-1:0] OFF_GEN      = 12'h000;
  localparam logic [RA_W-1:0] OFF_WEN      = 12'h020;
  localparam logic [RA_W-1:0] OFF_WIN0     = 12'h030;
  localparam logic [RA_W-1:0] OFF_RAW      = 12'h440;
  localparam logic [RA_W-1:0] OFF_MSTAT    = 12'h444;
  localparam logic [RA_W-1:0] OFF_MASK     = 12'h448;
  localparam logic [RA_W-1:0] OFF_FCFG     = 12'h450;
  localparam logic [RA_W-1:0] OFF_FADDR    = 12'h454;
  localparam logic [RA_W-1:0] OFF_FCLR     = 12'h45C;
  localparam logic [RA_W-1:0] OFF_STAT     = 12'h460;

  localparam logic [4:0] SL_LO   = 5'h00;
  localparam logic [4:0] SL_HI   = 5'h08;
  localparam logic [4:0] SL_BLO  = 5'h10;
  localparam logic [4:0] SL_BHI  = 5'h14;
  localparam logic [4:0] SL_CFG  = 5'h18;

  typedef struct packed {
    logic [VA_W-1:0] lo;
    logic [VA_W-1:0] hi;
    logic [PA_W-1:0] base;
    logic [31:0]     cfg;
  } win_t;

  // inclusive range test
  function automatic logic covers(logic [VA_W-1:0] lo, logic [VA_W-1:0] hi,
                                  logic [VA_W-1:0] a);
    return (a >= lo) && (a <= hi);
  endfunction

  // base plus the address bits below the window size (size-1 == hi-lo)
  function automatic logic [PA_W-1:0] remap(logic [PA_W-1:0] base,
                                            logic [VA_W-1:0] lo,
                                            logic [VA_W-1:0] hi,
                                            logic [VA_W-1:0] a);
    return base + {{(PA_W-VA_W){1'b0}}, a & (hi - lo)};
  endfunction
endpackage

// File: rtl/axu_regs.sv
module axu_regs
  import axu_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [RA_W-1:0]      reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 err_raw,
  input  logic [VA_W-1:0]      err_addr,
  output logic                 glb_en,
  output logic [NUM_WIN-1:0]   win_en,
  output win_t [NUM_WIN-1:0]   wins,
  output logic                 irq_mask,
  output logic                 clr_evt
);
  localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam logic [RA_W-1:0] WIN_END = OFF_WIN0 + RA_W'(32 * NUM_WIN);

  logic            in_win;
  logic [RA_W-1:0] woff;
  logic [4:0]      slot;
  logic [6:0]      widx;
  logic [IW-1:0]   rsel;
  logic [31:0]     fault_cfg;
  win_t            rwin;

  assign in_win = (reg_addr >= OFF_WIN0) && (reg_addr < WIN_END);
  assign woff   = reg_addr - OFF_WIN0;
  assign slot   = woff[4:0];
  assign widx   = woff[11:5];
  assign rsel   = widx[IW-1:0];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    win_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (reg_we && in_win && widx == 7'(g)) begin
        case (slot)
          SL_LO:   r.lo <= reg_wdata;
          SL_HI:   r.hi <= reg_wdata;
          SL_BLO:  r.base[31:0] <= reg_wdata;
          SL_BHI:  r.base[63:32] <= reg_wdata;
          SL_CFG:  r.cfg <= reg_wdata;
          default: ;
        endcase
      end
    end
    assign wins[g] = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en    <= 1'b0;
      win_en    <= '0;
      irq_mask  <= 1'b0;
      fault_cfg <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFF_GEN:  glb_en    <= reg_wdata[0];
        OFF_WEN:  win_en    <= reg_wdata[NUM_WIN-1:0];
        OFF_MASK: irq_mask  <= reg_wdata[0];
        OFF_FCFG: fault_cfg <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign clr_evt = reg_we && (reg_addr == OFF_FCLR) && reg_wdata[0];

  assign rwin = wins[rsel];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_GEN:   reg_rdata = {31'b0, glb_en};
      OFF_WEN:   reg_rdata = 32'(win_en);
      OFF_RAW:   reg_rdata = {31'b0, err_raw};
      OFF_MSTAT: reg_rdata = {31'b0, err_raw & ~irq_mask};
      OFF_MASK:  reg_rdata = {31'b0, irq_mask};
      OFF_FCFG:  reg_rdata = fault_cfg;
      OFF_FADDR: reg_rdata = err_addr;
      OFF_STAT:  reg_rdata = {30'b0, err_raw, glb_en};
      default: begin
        if (in_win) begin
          case (slot)
            SL_LO:   reg_rdata = rwin.lo;
            SL_HI:   reg_rdata = rwin.hi;
            SL_BLO:  reg_rdata = rwin.base[31:0];
            SL_BHI:  reg_rdata = rwin.base[63:32];
            SL_CFG:  reg_rdata = rwin.cfg;
            default: reg_rdata = '0;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/axu_match.sv
module axu_match
  import axu_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  win_t [NUM_WIN-1:0] wins,
  input  logic [NUM_WIN-1:0] win_en,
  input  logic [VA_W-1:0]    addr,
  output logic [NUM_WIN-1:0] sel_vec,
  output logic               hit,
  output logic [PA_W-1:0]    pa
);
  logic [NUM_WIN-1:0] raw;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign raw[g] = win_en[g] && covers(wins[g].lo, wins[g].hi, addr);
  end

  // lowest index wins
  always_comb begin
    logic found;
    found   = 1'b0;
    sel_vec = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (raw[i] && !found) begin
        sel_vec[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    pa = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (sel_vec[i]) pa = pa | remap(wins[i].base, wins[i].lo, wins[i].hi, addr);
    end
  end

  assign hit = |raw;
endmodule

// File: rtl/axu_fault.sv
module axu_fault
  import axu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            miss_evt,
  input  logic [VA_W-1:0] miss_addr,
  input  logic            clr_evt,
  input  logic            irq_mask,
  output logic            err_raw,
  output logic [VA_W-1:0] err_addr,
  output logic            irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_raw  <= 1'b0;
      err_addr <= '0;
    end else begin
      if (miss_evt && (!err_raw || clr_evt)) err_addr <= miss_addr;
      err_raw <= miss_evt | (err_raw & ~clr_evt);
    end
  end

  assign irq = err_raw & ~irq_mask;
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import axu_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic             resp_hit,
  output logic [63:0]      resp_addr,
  output logic             irq
);
  logic               glb_en;
  logic [NUM_WIN-1:0] win_en;
  win_t [NUM_WIN-1:0] wins;
  logic               irq_mask;
  logic               clr_evt;
  logic               err_raw;
  logic [VA_W-1:0]    err_addr;
  logic [NUM_WIN-1:0] sel_vec;
  logic               hit;
  logic [PA_W-1:0]    pa;
  logic               acc_evt;
  logic               miss_evt;

  axu_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .err_raw, .err_addr, .glb_en, .win_en, .wins, .irq_mask, .clr_evt
  );

  axu_match #(.NUM_WIN(NUM_WIN)) u_match (
    .wins, .win_en, .addr(req_addr), .sel_vec, .hit, .pa
  );

  assign req_ready = !resp_valid || resp_ready;
  assign acc_evt   = req_valid && req_ready;
  assign miss_evt  = acc_evt && glb_en && !hit;

  axu_fault u_fault (
    .clk, .rst_n, .miss_evt, .miss_addr(req_addr), .clr_evt, .irq_mask,
    .err_raw, .err_addr, .irq
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_addr  <= '0;
    end else if (acc_evt) begin
      resp_valid <= 1'b1;
      resp_hit   <= glb_en && hit;
      if (!glb_en)  resp_addr <= {{(PA_W-VA_W){1'b0}}, req_addr};
      else if (hit) resp_addr <= pa;
      else          resp_addr <= '0;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/axu_chk.sv
module axu_chk #(
  parameter int NUM_WIN = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               resp_valid,
  input logic               resp_ready,
  input logic               resp_hit,
  input logic [63:0]        resp_addr,
  input logic               irq,
  input logic               err_raw,
  input logic [31:0]        err_addr,
  input logic               miss_evt,
  input logic               clr_evt,
  input logic [NUM_WIN-1:0] sel_vec
);
  // R5
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

  // R7
  fault_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> err_raw);

  // R7
  fault_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_raw && !clr_evt) |=> $stable(err_addr));

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err_raw);

  // R9
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !miss_evt) |=> !err_raw);

  // R10
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_addr) && $stable(resp_hit)));
endmodule

bind addr_xlate_unit axu_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .resp_valid(resp_valid), .resp_ready(resp_ready),
  .resp_hit(resp_hit), .resp_addr(resp_addr), .irq(irq), .err_raw(err_raw),
  .err_addr(err_addr), .miss_evt(miss_evt), .clr_evt(clr_evt), .sel_vec(sel_vec)
);

// File: tb/addr_xlate_unit_test.sv
`timescale 1ns/1ps
module addr_xlate_unit_test;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_hit;
  logic [63:0] resp_addr;
  logic        irq;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_lo [NW];
  logic [31:0] m_hi [NW];
  logic [63:0] m_base [NW];
  logic [NW-1:0] m_en;

  always #2.5 clk = ~clk;

  addr_xlate_unit #(.NUM_WIN(NW)) uut (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic set_win(int n, logic [31:0] lo, logic [31:0] hi, logic [63:0] base);
    logic [11:0] o;
    o = 12'(32 * n);
    m_lo[n] = lo; m_hi[n] = hi; m_base[n] = base;
    wr(12'h030 + o, lo);
    wr(12'h038 + o, hi);
    wr(12'h040 + o, base[31:0]);
    wr(12'h044 + o, base[63:32]);
    wr(12'h048 + o, 32'hC0DE_0000 | 32'(n));
  endtask

  // one request, response checked one cycle after acceptance
  task automatic xlate(string tag, logic [31:0] a, logic exp_hit, logic [63:0] exp_pa);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; resp_ready = 1'b1;
    #1;
    check({tag, " ready"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check({tag, " valid"}, 64'(resp_valid), 64'd1);
    check({tag, " hit"}, 64'(resp_hit), 64'(exp_hit));
    check({tag, " addr"}, resp_addr, exp_pa);
  endtask

  // reference: lowest enabled window covering a
  task automatic model(logic [31:0] a, output logic h, output logic [63:0] p);
    h = 1'b0; p = '0;
    for (int n = NW - 1; n >= 0; n--) begin
      if (m_en[n] && a >= m_lo[n] && a <= m_hi[n]) begin
        h = 1'b1;
        p = m_base[n] + 64'(a - m_lo[n]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic h;
    logic [63:0] p;
    logic [31:0] pts [7];
    for (int n = 0; n < NW; n++) begin m_lo[n] = '0; m_hi[n] = '0; m_base[n] = '0; end
    m_en = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 gen", 12'h000, 32'd0);
    rd_chk("R1 wen", 12'h020, 32'd0);
    rd_chk("R1 raw", 12'h440, 32'd0);
    rd_chk("R1 faddr", 12'h454, 32'd0);
    rd_chk("R1 stat", 12'h460, 32'd0);
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 resp_valid", 64'(resp_valid), 64'd0);

    // R11 unimplemented bits and windows
    wr(12'h020, 32'hFFFF_FFFF);
    rd_chk("R11 wen width", 12'h020, 32'h0000_00FF);
    wr(12'h020, 32'h0);
    wr(12'h030 + 12'(32 * NW), 32'h1234_5678);
    rd_chk("R11 window beyond", 12'h030 + 12'(32 * NW), 32'd0);

    // R2 program windows with translation off
    set_win(0, 32'h0001_0000, 32'h0001_0FFF, 64'h0000_0001_8000_0000);
    set_win(1, 32'h0002_0000, 32'h0002_FFFF, 64'h0000_00AB_0000_0000);
    set_win(2, 32'h0001_0000, 32'h0001_FFFF, 64'h2222_0000_0000_0000);
    set_win(3, 32'h4000_0000, 32'h7FFF_FFFF, 64'h0000_0010_0000_0000);
    set_win(4, 32'h0008_0000, 32'h0008_0FFF, 64'h0000_0005_0000_1000);
    for (int n = 0; n < 5; n++) begin
      rd_chk("R2 lo", 12'h030 + 12'(32 * n), m_lo[n]);
      rd_chk("R2 hi", 12'h038 + 12'(32 * n), m_hi[n]);
      rd_chk("R2 base lo", 12'h040 + 12'(32 * n), m_base[n][31:0]);
      rd_chk("R2 base hi", 12'h044 + 12'(32 * n), m_base[n][63:32]);
      rd_chk("R2 cfg", 12'h048 + 12'(32 * n), 32'hC0DE_0000 | 32'(n));
    end

    // R6 translation off: bypass, no fault
    xlate("R6 bypass", 32'h0001_0010, 1'b0, 64'h0000_0000_0001_0010);
    rd_chk("R6 no fault", 12'h440, 32'd0);

    m_en = 8'h0F;
    wr(12'h020, 32'h0000_000F);
    wr(12'h000, 32'd1);
    rd_chk("R12 stat en", 12'h460, 32'd1);

    // R3 R4 R5 R7 boundary sweep
    for (int n = 0; n < 5; n++) begin
      pts[0] = m_lo[n] - 1; pts[1] = m_lo[n]; pts[2] = m_lo[n] + 1;
      pts[3] = m_hi[n] - 1; pts[4] = m_hi[n]; pts[5] = m_hi[n] + 1;
      pts[6] = m_lo[n] + ((m_hi[n] - m_lo[n]) >> 1);
      for (int k = 0; k < 7; k++) begin
        model(pts[k], h, p);
        xlate("R3 R4 R5 sweep", pts[k], h, p);
        if (!h) begin
          check("R8 irq on miss", 64'(irq), 64'd1);
          rd_chk("R7 raw", 12'h440, 32'd1);
          rd_chk("R7 faddr", 12'h454, pts[k]);
          wr(12'h45C, 32'd1);
          rd_chk("R9 cleared", 12'h440, 32'd0);
        end
      end
    end

    // R5 explicit overlap: window 0 over window 2
    xlate("R5 overlap", 32'h0001_0ABC, 1'b1, 64'h0000_0001_8000_0ABC);
    xlate("R4 upper part", 32'h0001_8ABC, 1'b1, 64'h2222_0000_0000_8ABC);

    // R7 first fault held
    xlate("R7 miss a", 32'h0000_0100, 1'b0, 64'd0);
    xlate("R7 miss b", 32'h0000_0200, 1'b0, 64'd0);
    rd_chk("R7 first kept", 12'h454, 32'h0000_0100);
    rd_chk("R12 stat err", 12'h460, 32'd3);

    // R8 masking
    rd_chk("R8 mstat", 12'h444, 32'd1);
    wr(12'h448, 32'd1);
    check("R8 irq masked", 64'(irq), 64'd0);
    rd_chk("R8 mstat masked", 12'h444, 32'd0);
    rd_chk("R8 raw masked", 12'h440, 32'd1);
    wr(12'h448, 32'd0);
    check("R8 irq unmasked", 64'(irq), 64'd1);

    // R9 clear and miss together
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h45C; reg_wdata = 32'd1;
    req_valid = 1'b1; req_addr = 32'h0000_0300;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    rd_chk("R9 flag stays", 12'h440, 32'd1);
    rd_chk("R9 new addr", 12'h454, 32'h0000_0300);
    wr(12'h45C, 32'd1);
    check("R9 irq released", 64'(irq), 64'd0);

    // R10 backpressure
    @(negedge clk);
    resp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0002_0010;
    @(negedge clk);
    req_addr = 32'h4000_0020;
    #1;
    check("R10 valid", 64'(resp_valid), 64'd1);
    check("R10 not ready", 64'(req_ready), 64'd0);
    repeat (2) @(negedge clk);
    #1;
    check("R10 held addr", resp_addr, 64'h0000_00AB_0000_0010);
    check("R10 held hit", 64'(resp_hit), 64'd1);
    resp_ready = 1'b1;
    #1;
    check("R10 ready follows", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R10 next resp", resp_addr, 64'h0000_0010_0000_0020);
    @(negedge clk);
    #1;
    check("R10 drained", 64'(resp_valid), 64'd0);

    // R6 disable after use
    wr(12'h000, 32'd0);
    xlate("R6 off again", 32'h4000_0020, 1'b0, 64'h0000_0000_4000_0020);
    rd_chk("R6 no fault again", 12'h440, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule